// File: doc/BRIEF.md
# Calendar Time Counter

This block is the timekeeping core of a real-time clock. Each one-second tick advances a chain of eight fields (seconds, minutes, hours, day of week, day of month, month, year within the century, and century), with carries moving from each field into the next. One mode input stores every field either as packed BCD or as plain binary. A second mode input picks 24-hour hours or 12-hour hours with a PM flag. Month lengths follow the calendar, and any year value divisible by four is a leap year.

The host freezes the counter with a hold input before it reads or writes the fields as a coherent set. While hold is high, a load strobe writes one raw byte into the field that a select code names, and any tick that arrives is discarded. A busy output marks the cycle in which an accepted tick is about to be applied. A one-cycle done pulse follows each completed update.

Top module: `caltime_core`

## Requirements
- R1: After reset, seconds, minutes, hour, year and century read 0x00, day of week, day of month and month read 0x01, and busy_o and upd_done_o are 0.
- R2: A tick sampled high with hold_i low drives busy_o high for the next cycle. At the following clock edge the fields take their new values and upd_done_o is high for that one cycle, provided no further tick arrived.
- R3: Seconds and minutes count 0 to 59. Seconds wrap from 59 to 0 and carry into minutes, and minutes wrap from 59 to 0 and carry into the hour.
- R4: With h24_mode_i = 1 the hour counts 0 to 23. On 23 to 0 it advances both day of week and day of month.
- R5: With h24_mode_i = 0, hour bit 7 is the PM flag (1 = PM) and bits 6:0 hold 1 to 12. 11 AM advances to 12 PM, 12 PM advances to 1 PM, and 11 PM advances to 12 AM together with a day increment.
- R6: bin_mode_i = 0 stores every field as BCD (tens in bits 7:4, units in bits 3:0), and bin_mode_i = 1 stores it as plain binary. Example: 59 is 0x59 in BCD and 24 is 0x18 in binary.
- R7: Day of week counts 1 to 7 (1 = Sunday) and wraps from 7 to 1.
- R8: Day of month wraps to 1 after the month's last day: 30 days in April, June, September and November, 31 in the other months, and February has 29 days when the year is divisible by 4 and 28 otherwise.
- R9: Month wraps from 12 to 1 and carries into the year. Year wraps from 99 to 0 and carries into the century, and the century wraps from 99 to 0.
- R10: While hold_i is 1 the fields do not advance. A tick seen under hold is discarded: busy_o stays 0, and no update or done pulse follows after hold is released.
- R11: With hold_i = 1, ld_en_i writes ld_data_i unchanged into the field picked by ld_sel_i (0 seconds, 1 minutes, 2 hour, 3 day of week, 4 day of month, 5 month, 6 year, 7 century). With hold_i = 0, ld_en_i has no effect.
- R12: If hold_i is 1 in the cycle where busy_o is 1, the pending update is dropped: the fields keep their values and no done pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-second advance request, one cycle wide |
| bin_mode_i | input | 1 | Field encoding: 0 BCD, 1 binary |
| h24_mode_i | input | 1 | Hour format: 1 24-hour, 0 12-hour with PM flag |
| hold_i | input | 1 | Freeze counting and enable host loads |
| ld_en_i | input | 1 | Host load strobe |
| ld_sel_i | input | 3 | Field select for the load |
| ld_data_i | input | 8 | Raw byte to load |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hour (bit 7 is PM in 12-hour mode) |
| dow_o | output | 8 | Day of week |
| dom_o | output | 8 | Day of month |
| mon_o | output | 8 | Month |
| year_o | output | 8 | Year within century |
| cent_o | output | 8 | Century |
| busy_o | output | 1 | Update in progress |
| upd_done_o | output | 1 | Update-ended pulse |

## Verification
An accepted tick has two results due at different times. busy_o is due one cycle after the edge that samples the tick. The new field values and the done pulse are due one cycle after that, and the done pulse must be gone again on the cycle after it. The driver raises the tick just after a falling edge and samples busy_o, then the done pulse, then the pulse's end on the three falling edges that follow, so every sample sits half a cycle clear of the edge that produced it. The scoreboard pushes the expected field set when the tick is driven and pops it only on a done pulse. A done pulse with no expected entry waiting, as after a discarded tick or a dropped update, is reported as a failure.

// File: rtl/caltime_pkg.sv
package caltime_pkg;

   localparam int unsigned NFLD   = 8;
   localparam int unsigned SELW   = $clog2(NFLD);

   localparam int IX_SEC  = 0;
   localparam int IX_MIN  = 1;
   localparam int IX_HOUR = 2;
   localparam int IX_DOW  = 3;
   localparam int IX_DOM  = 4;
   localparam int IX_MON  = 5;
   localparam int IX_YEAR = 6;
   localparam int IX_CENT = 7;

   // Raw field byte to a binary value 0..99.
   function automatic logic [6:0] fld_dec(input logic [7:0] raw, input logic bin);
      logic [7:0] t;
      t = 8'(raw[7:4]) * 8'd10 + 8'(raw[3:0]);
      return bin ? raw[6:0] : t[6:0];
   endfunction

   // Binary value 0..99 to a raw field byte.
   function automatic logic [7:0] fld_enc(input logic [6:0] v, input logic bin);
      return bin ? {1'b0, v} : {4'(v / 7'd10), 4'(v % 7'd10)};
   endfunction

   function automatic logic [6:0] month_len(input logic [6:0] mon, input logic [6:0] yr);
      case (mon)
         7'd4, 7'd6, 7'd9, 7'd11: return 7'd30;
         7'd2:                    return (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
         default:                 return 7'd31;
      endcase
   endfunction

   function automatic logic [6:0] fld_lo(input int ix);
      return (ix == IX_DOW || ix == IX_DOM || ix == IX_MON) ? 7'd1 : 7'd0;
   endfunction

   function automatic logic [6:0] fld_hi(input int ix);
      case (ix)
         IX_SEC, IX_MIN:   return 7'd59;
         IX_HOUR:          return 7'd23;
         IX_DOW:           return 7'd7;
         IX_DOM:           return 7'd31;
         IX_MON:           return 7'd12;
         default:          return 7'd99;
      endcase
   endfunction

endpackage

// File: rtl/caltime_step.sv
module caltime_step
   import caltime_pkg::*;
#(
   parameter int unsigned FW = 8
) (
   input  logic [FW-1:0] cur_i,
   input  logic          bin_i,
   input  logic [6:0]    lo_i,
   input  logic [6:0]    hi_i,
   input  logic          inc_i,
   output logic [FW-1:0] nxt_o,
   output logic          at_top_o
);

   initial begin
      if (FW != 8) $fatal(1, "caltime_step: FW must be 8");
   end

   logic [6:0] val;
   logic [6:0] val_nxt;

   always_comb begin
      val      = fld_dec(cur_i, bin_i);
      at_top_o = (val >= hi_i);
      val_nxt  = at_top_o ? lo_i : val + 7'd1;
      nxt_o    = inc_i ? fld_enc(val_nxt, bin_i) : cur_i;
   end

endmodule

// File: rtl/caltime_hour.sv
module caltime_hour
   import caltime_pkg::*;
#(
   parameter int unsigned FW = 8
) (
   input  logic [FW-1:0] cur_i,
   input  logic          bin_i,
   input  logic          h24_i,
   input  logic          inc_i,
   output logic [FW-1:0] nxt_o,
   output logic          at_top_o
);

   initial begin
      if (FW != 8) $fatal(1, "caltime_hour: FW must be 8");
   end

   logic [6:0] low12;
   logic [6:0] h24v;
   logic [6:0] n24;
   logic [6:0] m12;
   logic       pm_nxt;
   logic [7:0] enc24;
   logic [7:0] enc12;

   always_comb begin
      low12 = fld_dec({1'b0, cur_i[6:0]}, bin_i);
      if (h24_i) begin
         h24v = fld_dec(cur_i, bin_i);
      end else begin
         h24v = ((low12 == 7'd12) ? 7'd0 : low12) + (cur_i[7] ? 7'd12 : 7'd0);
      end
      at_top_o = (h24v >= 7'd23);
      n24      = at_top_o ? 7'd0 : h24v + 7'd1;
      pm_nxt   = (n24 >= 7'd12);
      m12      = n24 - (pm_nxt ? 7'd12 : 7'd0);
      if (m12 == 7'd0) m12 = 7'd12;
      enc24    = fld_enc(n24, bin_i);
      enc12    = fld_enc(m12, bin_i);
      if (!inc_i)      nxt_o = cur_i;
      else if (h24_i)  nxt_o = enc24;
      else             nxt_o = {pm_nxt, enc12[6:0]};
   end

endmodule

// File: rtl/caltime_core.sv
module caltime_core
   import caltime_pkg::*;
#(
   parameter int unsigned FW      = 8,
   parameter logic [7:0]  CENT_RST = 8'h00
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick_i,
   input  logic            bin_mode_i,
   input  logic            h24_mode_i,
   input  logic            hold_i,
   input  logic            ld_en_i,
   input  logic [SELW-1:0] ld_sel_i,
   input  logic [FW-1:0]   ld_data_i,
   output logic [FW-1:0]   sec_o,
   output logic [FW-1:0]   min_o,
   output logic [FW-1:0]   hour_o,
   output logic [FW-1:0]   dow_o,
   output logic [FW-1:0]   dom_o,
   output logic [FW-1:0]   mon_o,
   output logic [FW-1:0]   year_o,
   output logic [FW-1:0]   cent_o,
   output logic            busy_o,
   output logic            upd_done_o
);

   initial begin
      if (FW != 8) $fatal(1, "caltime_core: FW must be 8");
   end

   logic [FW-1:0] fld_q [NFLD];
   logic [FW-1:0] fld_nxt [NFLD];
   logic [NFLD-1:0] inc;
   logic [NFLD-1:0] at_top;
   logic            pend_q;
   logic            done_q;
   logic            commit;
   logic [6:0]      dom_hi;
   logic            unused_top;

   assign commit     = pend_q & ~hold_i;
   assign dom_hi     = month_len(fld_dec(fld_q[IX_MON], bin_mode_i),
                                 fld_dec(fld_q[IX_YEAR], bin_mode_i));
   assign unused_top = at_top[IX_DOW] ^ at_top[IX_CENT];

   // Carry chain: each field advances when all lower fields sit at their top.
   always_comb begin
      inc[IX_SEC]  = commit;
      inc[IX_MIN]  = inc[IX_SEC]  & at_top[IX_SEC];
      inc[IX_HOUR] = inc[IX_MIN]  & at_top[IX_MIN];
      inc[IX_DOW]  = inc[IX_HOUR] & at_top[IX_HOUR];
      inc[IX_DOM]  = inc[IX_HOUR] & at_top[IX_HOUR];
      inc[IX_MON]  = inc[IX_DOM]  & at_top[IX_DOM];
      inc[IX_YEAR] = inc[IX_MON]  & at_top[IX_MON];
      inc[IX_CENT] = inc[IX_YEAR] & at_top[IX_YEAR];
   end

   for (genvar gi = 0; gi < NFLD; gi++) begin : g_fld
      if (gi == IX_HOUR) begin : g_hour
         caltime_hour #(.FW(FW)) i_hour (
            .cur_i    (fld_q[gi]),
            .bin_i    (bin_mode_i),
            .h24_i    (h24_mode_i),
            .inc_i    (inc[gi]),
            .nxt_o    (fld_nxt[gi]),
            .at_top_o (at_top[gi])
         );
      end else begin : g_plain
         caltime_step #(.FW(FW)) i_step (
            .cur_i    (fld_q[gi]),
            .bin_i    (bin_mode_i),
            .lo_i     (fld_lo(gi)),
            .hi_i     ((gi == IX_DOM) ? dom_hi : fld_hi(gi)),
            .inc_i    (inc[gi]),
            .nxt_o    (fld_nxt[gi]),
            .at_top_o (at_top[gi])
         );
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         done_q <= 1'b0;
         for (int k = 0; k < NFLD; k++) begin
            fld_q[k] <= FW'(fld_lo(k));
         end
         fld_q[IX_CENT] <= CENT_RST;
      end else begin
         pend_q <= tick_i & ~hold_i;
         done_q <= commit;
         if (hold_i && ld_en_i) begin
            fld_q[ld_sel_i] <= ld_data_i;
         end else if (commit) begin
            for (int k = 0; k < NFLD; k++) begin
               fld_q[k] <= fld_nxt[k];
            end
         end
      end
   end

   assign sec_o      = fld_q[IX_SEC];
   assign min_o      = fld_q[IX_MIN];
   assign hour_o     = fld_q[IX_HOUR];
   assign dow_o      = fld_q[IX_DOW];
   assign dom_o      = fld_q[IX_DOM];
   assign mon_o      = fld_q[IX_MON];
   assign year_o     = fld_q[IX_YEAR];
   assign cent_o     = fld_q[IX_CENT];
   assign busy_o     = pend_q;
   assign upd_done_o = done_q;

endmodule

// File: rtl/caltime_chk.sv
module caltime_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tick_i,
   input logic       hold_i,
   input logic       ld_en_i,
   input logic [7:0] sec_o,
   input logic [7:0] min_o,
   input logic [7:0] hour_o,
   input logic [7:0] dow_o,
   input logic [7:0] dom_o,
   input logic [7:0] mon_o,
   input logic [7:0] year_o,
   input logic [7:0] cent_o,
   input logic       busy_o,
   input logic       upd_done_o
);

   // R2
   tick_to_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !hold_i) |=> busy_o);

   // R2
   busy_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !hold_i) |=> upd_done_o);

   // R2
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_done_o |-> $past(busy_o));

   // R10
   hold_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold_i |=> !upd_done_o);

   // R10
   hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_i && !ld_en_i) |=> $stable({sec_o, min_o, hour_o, dow_o, dom_o, mon_o, year_o, cent_o}));

   // R11
   idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !(hold_i && ld_en_i)) |=> $stable({sec_o, min_o, hour_o, dow_o, dom_o, mon_o, year_o, cent_o}));

endmodule

bind caltime_core caltime_chk i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick_i     (tick_i),
   .hold_i     (hold_i),
   .ld_en_i    (ld_en_i),
   .sec_o      (sec_o),
   .min_o      (min_o),
   .hour_o     (hour_o),
   .dow_o      (dow_o),
   .dom_o      (dom_o),
   .mon_o      (mon_o),
   .year_o     (year_o),
   .cent_o     (cent_o),
   .busy_o     (busy_o),
   .upd_done_o (upd_done_o)
);

// File: tb/test_caltime_core.sv
module test_caltime_core;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0;
   logic       bin_mode_i = 1'b0;
   logic       h24_mode_i = 1'b1;
   logic       hold_i = 1'b0;
   logic       ld_en_i = 1'b0;
   logic [2:0] ld_sel_i = 3'd0;
   logic [7:0] ld_data_i = 8'd0;
   logic [7:0] sec_o, min_o, hour_o, dow_o, dom_o, mon_o, year_o, cent_o;
   logic       busy_o, upd_done_o;

   always #2.5 clk = ~clk;

   caltime_core i_caltime_core (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bin_mode_i(bin_mode_i),
      .h24_mode_i(h24_mode_i), .hold_i(hold_i), .ld_en_i(ld_en_i),
      .ld_sel_i(ld_sel_i), .ld_data_i(ld_data_i),
      .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
      .dom_o(dom_o), .mon_o(mon_o), .year_o(year_o), .cent_o(cent_o),
      .busy_o(busy_o), .upd_done_o(upd_done_o)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;
   string tag = "R1";
   logic [63:0] exp_q[$];

   // reference model, binary values, hour always 0..23
   int s = 0, m = 0, h = 0, dw = 1, dd = 1, mo = 1, y = 0, c = 0;

   function automatic logic [7:0] enc(int v);
      return bin_mode_i ? 8'(v) : 8'(((v / 10) << 4) | (v % 10));
   endfunction

   function automatic logic [7:0] henc(int hv);
      int x;
      logic [7:0] e;
      if (h24_mode_i) return enc(hv);
      x = hv % 12;
      if (x == 0) x = 12;
      e = enc(x);
      return {(hv >= 12) ? 1'b1 : 1'b0, e[6:0]};
   endfunction

   function automatic int mdays(int mm, int yy);
      if (mm == 4 || mm == 6 || mm == 9 || mm == 11) return 30;
      if (mm == 2) return (yy % 4 == 0) ? 29 : 28;
      return 31;
   endfunction

   function automatic logic [63:0] snap();
      return {enc(c), enc(y), enc(mo), enc(dd), enc(dw), henc(h), enc(m), enc(s)};
   endfunction

   function automatic logic [63:0] outs();
      return {cent_o, year_o, mon_o, dom_o, dow_o, hour_o, min_o, sec_o};
   endfunction

   task automatic model_adv();
      s++;
      if (s == 60) begin
         s = 0; m++;
         if (m == 60) begin
            m = 0; h++;
            if (h == 24) begin
               h = 0;
               dw = (dw == 7) ? 1 : dw + 1;
               dd++;
               if (dd > mdays(mo, y)) begin
                  dd = 1; mo++;
                  if (mo == 13) begin
                     mo = 1; y++;
                     if (y == 100) begin
                        y = 0; c = (c + 1) % 100;
                     end
                  end
               end
            end
         end
      end
   endtask

   task automatic chk(input string t, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", t, act, exp);
      end
   endtask

   // monitor: pops one expected item per update-ended pulse
   always @(negedge clk) begin
      if (rst_n && upd_done_o) begin
         if (exp_q.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL %s/R10/R12 unexpected update actual=%h expected=none", tag, outs());
         end else begin
            chk({tag, " fields"}, outs(), exp_q.pop_front());
         end
      end
   end

   task automatic do_tick();
      @(negedge clk) tick_i = 1'b1;
      model_adv();
      exp_q.push_back(snap());
      @(negedge clk) tick_i = 1'b0;
      chk("R2 busy", 64'(busy_o), 64'd1);
      chk("R2 not early", 64'(upd_done_o), 64'd0);
      @(negedge clk) chk("R2 done", 64'(upd_done_o), 64'd1);
      @(negedge clk) chk("R2 done width", 64'(upd_done_o), 64'd0);
   endtask

   task automatic load_all();
      logic [63:0] v;
      v = snap();
      @(negedge clk) hold_i = 1'b1;
      for (int k = 0; k < 8; k++) begin
         ld_en_i = 1'b1; ld_sel_i = 3'(k); ld_data_i = v[8*k +: 8];
         @(negedge clk);
      end
      ld_en_i = 1'b0;
      hold_i = 1'b0;
      chk("R11 load", outs(), v);
   endtask

   task automatic set_time(int cc, int yy, int mm, int d, int w, int hh, int mi, int se);
      c = cc; y = yy; mo = mm; dd = d; dw = w; h = hh; m = mi; s = se;
      load_all();
   endtask

   initial begin
      #(5 * 150000);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk("R1 reset fields", outs(), 64'h00000101_01000000);
      chk("R1 reset flags", {62'd0, busy_o, upd_done_o}, 64'd0);

      // BCD, 24-hour: second rollover then full carry to the century (R3 R4 R6 R7 R9)
      tag = "R3";
      set_time(19, 99, 12, 31, 7, 23, 59, 58);
      do_tick();
      chk("R6 bcd sec", 64'(sec_o), 64'h59);
      tag = "R4/R7/R9";
      do_tick();
      chk("R9 century", 64'(cent_o), 64'h20);

      // binary mode: leap rules (R6 R8)
      bin_mode_i = 1'b1;
      tag = "R8 non-leap";
      set_time(20, 23, 2, 28, 2, 23, 59, 59);
      do_tick();
      tag = "R8 leap";
      set_time(20, 24, 2, 28, 2, 23, 59, 59);
      do_tick();
      chk("R6 bin dom", 64'(dom_o), 64'h1D);
      chk("R6 bin year", 64'(year_o), 64'h18);
      h = 23; m = 59; s = 59;
      load_all();
      do_tick();

      // century wrap 99 -> 0 (R9)
      tag = "R9";
      set_time(99, 99, 12, 31, 5, 23, 59, 59);
      do_tick();

      // 12-hour BCD (R5)
      bin_mode_i = 1'b0;
      h24_mode_i = 1'b0;
      tag = "R5 11AM";
      set_time(20, 25, 6, 10, 3, 11, 59, 59);
      do_tick();
      chk("R5 12PM raw", 64'(hour_o), 64'h92);
      tag = "R5 12PM";
      set_time(20, 25, 6, 10, 3, 12, 59, 59);
      do_tick();
      chk("R5 1PM raw", 64'(hour_o), 64'h81);
      tag = "R5 11PM/R8";
      set_time(20, 25, 4, 30, 3, 23, 59, 59);
      do_tick();
      chk("R5 12AM raw", 64'(hour_o), 64'h12);

      // R10: tick under hold discarded
      tag = "R10";
      @(negedge clk) begin hold_i = 1'b1; tick_i = 1'b1; end
      @(negedge clk) tick_i = 1'b0;
      chk("R10 no busy", 64'(busy_o), 64'd0);
      repeat (3) @(negedge clk);
      chk("R10 frozen", outs(), snap());
      hold_i = 1'b0;
      repeat (4) @(negedge clk);
      chk("R10 after release", outs(), snap());

      // R11: load without hold ignored
      tag = "R11";
      @(negedge clk) begin ld_en_i = 1'b1; ld_sel_i = 3'd0; ld_data_i = 8'h33; end
      @(negedge clk) ld_en_i = 1'b0;
      chk("R11 ignored", outs(), snap());

      // R12: hold in the busy cycle drops the update
      tag = "R12";
      @(negedge clk) tick_i = 1'b1;
      @(negedge clk) begin tick_i = 1'b0; hold_i = 1'b1; end
      chk("R12 busy", 64'(busy_o), 64'd1);
      @(negedge clk) chk("R12 no done", 64'(upd_done_o), 64'd0);
      hold_i = 1'b0;
      repeat (3) @(negedge clk);
      chk("R12 unchanged", outs(), snap());

      // one more normal tick after all that (R3)
      tag = "R3 resume";
      do_tick();
      chk("R2 queue empty", 64'(exp_q.size()), 64'd0);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule